// File: doc/BRIEF.md
# Routed Two-Stage Priority Interrupt Controller

This block collects interrupt requests from up to eight external pins and presents a single prioritised request to the processor. A configurable crossbar sits in front of the priority logic and assigns each external pin to one of fifteen internal interrupt levels. Two eight-level priority controllers resolve those levels. The secondary controller handles levels 8 to 15, and its request output drives input 2 of the primary controller. Each controller keeps request, mask and in-service state. When the processor acknowledges, the block returns an 8-bit vector number. Software retires service with a non-specific end-of-interrupt command, addressed to one controller at a time.

Configuration uses a small write-only port. Addresses 0 to 7 select the route of the matching pin. Address 8 holds the primary mask, address 9 the secondary mask, address 10 the primary vector base and address 11 the secondary vector base. A one-cycle wake pulse tells the power manager that a new unmasked request has arrived.

Top module: `irq_cascade_router`

## Requirements
- R1: After reset, int_req, vec_valid and wake are low, and every pin's route holds code 2, which means the pin is unrouted.
- R2: A pin whose route code is k (written as cfg_wdata[3:0] to address equal to the pin index), with k not equal to 2, drives level k. A rising edge on it raises int_req one cycle later for levels 0, 1 and 3 to 7, and two cycles later for levels 8 to 15.
- R3: A pin routed with code 2 never raises int_req or wake.
- R4: A masked level keeps its request pending without raising int_req. Mask bit n at address 8 masks primary level n, and address 9 does the same for secondary level 8+n. Clearing the mask bit raises int_req on the cycle after the write.
- R5: When several requests are pending, acknowledges serve them in the order 0, 1, 8 to 15, 3 to 7.
- R6: After an acknowledge, int_req stays low while only equal or lower priority requests are pending. A request that outranks the level in service raises int_req.
- R7: A one-cycle pulse on inta gives vec_valid high in the next cycle, with vec_out equal to the controller's base in bits 7:3 and its 3-bit level in bits 2:0. The bases are written at addresses 10 and 11 from cfg_wdata[7:3]. Reset bases are 0x08 and 0x70.
- R8: Requests are edge triggered. A pin held high produces one request only. A new request needs the pin to go low and then high again.
- R9: With eoi_slave low, eoi_valid clears the highest-priority in-service level of the primary controller. With eoi_slave high, it does the same for the secondary controller. A secondary interrupt keeps the primary level 2 in service until the primary receives its own end-of-interrupt.
- R10: An acknowledge while int_req is low returns primary base with level 7 and changes no in-service state.
- R11: wake pulses high for exactly one cycle, one cycle after an unmasked routed rising edge. A masked edge does not pulse it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq | input | NUM_PINS | External request pins |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| inta | input | 1 | Interrupt acknowledge pulse |
| eoi_valid | input | 1 | End-of-interrupt command strobe |
| eoi_slave | input | 1 | End-of-interrupt target: 1 selects the secondary controller |
| int_req | output | 1 | Request to the processor |
| vec_valid | output | 1 | Vector output is valid |
| vec_out | output | 8 | Vector number |
| wake | output | 1 | Wake pulse for the power manager |

## Verification
Primary levels register the pin edge once, so int_req and wake are sampled just after the first clock edge that follows the pin change. Secondary levels pass through one extra register at the primary cascade input, so the bench sees int_req low after the first edge and high after the second. The vector and vec_valid are registered on the acknowledge edge. End-of-interrupt and mask writes take effect at the edge that applies them. Every check is therefore sampled one nanosecond after the specific edge where the result first becomes visible.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int unsigned LVL_N   = 8;
   localparam int unsigned IDX_W   = $clog2(LVL_N);
   localparam int unsigned VEC_W   = 8;
   localparam int unsigned BASE_W  = VEC_W - IDX_W;
   localparam int unsigned LINES_N = 2 * LVL_N;
   localparam int unsigned RT_W    = $clog2(LINES_N);
   localparam int unsigned CFG_AW  = 4;

   localparam logic [CFG_AW-1:0] A_MMASK = 4'd8;
   localparam logic [CFG_AW-1:0] A_SMASK = 4'd9;
   localparam logic [CFG_AW-1:0] A_MBASE = 4'd10;
   localparam logic [CFG_AW-1:0] A_SBASE = 4'd11;

   typedef logic [LVL_N-1:0] lvl_vec_t;

   typedef struct packed {
      logic             hit;
      logic [IDX_W-1:0] idx;
   } pick_t;

   // lowest index set wins: index 0 is highest priority
   function automatic pick_t first_set(lvl_vec_t v);
      pick_t r;
      r = '0;
      for (int i = LVL_N - 1; i >= 0; i--) begin
         if (v[i]) begin
            r.hit = 1'b1;
            r.idx = IDX_W'(i);
         end
      end
      return r;
   endfunction
endpackage

// File: rtl/irq_route_xbar.sv
module irq_route_xbar
   import irq_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 8,
   parameter int unsigned CASCADE_LVL = 2
) (
   input  logic [NUM_PINS-1:0]      pins_i,
   input  logic [NUM_PINS*RT_W-1:0] route_i,
   output logic [LINES_N-1:0]       lines_o
);
   for (genvar k = 0; k < LINES_N; k++) begin : g_line
      if (k == CASCADE_LVL) begin : g_unused
         assign lines_o[k] = 1'b0;
      end else begin : g_or
         logic acc;
         always_comb begin
            acc = 1'b0;
            for (int p = 0; p < NUM_PINS; p++) begin
               if (route_i[p*RT_W +: RT_W] == RT_W'(k)) acc = acc | pins_i[p];
            end
         end
         assign lines_o[k] = acc;
      end
   end
endmodule

// File: rtl/irq_pic_core.sv
module irq_pic_core
   import irq_pkg::*;
#(
   parameter lvl_vec_t LEVEL_BITS = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  lvl_vec_t         line_i,
   input  lvl_vec_t         mask_i,
   input  logic             ack_i,
   input  logic             eoi_i,
   output logic             req_o,
   output logic [IDX_W-1:0] top_o,
   output logic             evt_o
);
   lvl_vec_t prev_q, irr_q, isr_q, irr_d, isr_d, rise, evt, take;
   pick_t    pend_p, svc_p;

   assign rise   = line_i & ~prev_q;
   assign pend_p = first_set(irr_q & ~mask_i);
   assign svc_p  = first_set(isr_q);
   assign req_o  = pend_p.hit && (!svc_p.hit || (pend_p.idx < svc_p.idx));
   assign top_o  = pend_p.idx;

   always_comb begin
      take = '0;
      if (ack_i && req_o) take[pend_p.idx] = 1'b1;
   end

   for (genvar b = 0; b < LVL_N; b++) begin : g_bit
      if (LEVEL_BITS[b]) begin : g_level
         assign irr_d[b] = line_i[b];
         assign evt[b]   = 1'b0;
      end else begin : g_edge
         assign irr_d[b] = rise[b] | (irr_q[b] & ~take[b]);
         assign evt[b]   = rise[b] & ~mask_i[b];
      end
   end

   assign evt_o = |evt;

   always_comb begin
      isr_d = isr_q;
      if (eoi_i && svc_p.hit) isr_d[svc_p.idx] = 1'b0;
      isr_d = isr_d | take;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= '0;
         irr_q  <= '0;
         isr_q  <= '0;
      end else begin
         prev_q <= line_i;
         irr_q  <= irr_d;
         isr_q  <= isr_d;
      end
   end
endmodule

// File: rtl/irq_cascade_router.sv
module irq_cascade_router
   import irq_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 8,
   parameter int unsigned CASCADE_LVL = 2,
   parameter logic [7:0]  MBASE_RST   = 8'h08,
   parameter logic [7:0]  SBASE_RST   = 8'h70
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] ext_irq,
   input  logic                cfg_we,
   input  logic [3:0]          cfg_addr,
   input  logic [7:0]          cfg_wdata,
   input  logic                inta,
   input  logic                eoi_valid,
   input  logic                eoi_slave,
   output logic                int_req,
   output logic                vec_valid,
   output logic [7:0]          vec_out,
   output logic                wake
);
   localparam lvl_vec_t CASC_BIT = lvl_vec_t'(1) << CASCADE_LVL;

   if (NUM_PINS < 1 || NUM_PINS > LVL_N) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..%0d", LVL_N);
   end
   if (CASCADE_LVL >= LVL_N) begin : g_bad_casc
      $error("CASCADE_LVL out of range");
   end

   logic [NUM_PINS*RT_W-1:0] route_q;
   lvl_vec_t                 m_mask, s_mask;
   logic [BASE_W-1:0]        m_base_q, s_base_q;
   logic [LINES_N-1:0]       lines;
   lvl_vec_t                 m_line, s_line;
   logic                     m_req, s_req, m_evt, s_evt, s_ack;
   logic [IDX_W-1:0]         m_top, s_top;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < NUM_PINS; p++) route_q[p*RT_W +: RT_W] <= RT_W'(CASCADE_LVL);
         m_mask   <= '0;
         s_mask   <= '0;
         m_base_q <= MBASE_RST[VEC_W-1:IDX_W];
         s_base_q <= SBASE_RST[VEC_W-1:IDX_W];
      end else if (cfg_we) begin
         for (int p = 0; p < NUM_PINS; p++) begin
            if (cfg_addr == CFG_AW'(p)) route_q[p*RT_W +: RT_W] <= cfg_wdata[RT_W-1:0];
         end
         if (cfg_addr == A_MMASK) m_mask   <= cfg_wdata;
         if (cfg_addr == A_SMASK) s_mask   <= cfg_wdata;
         if (cfg_addr == A_MBASE) m_base_q <= cfg_wdata[VEC_W-1:IDX_W];
         if (cfg_addr == A_SBASE) s_base_q <= cfg_wdata[VEC_W-1:IDX_W];
      end
   end

   irq_route_xbar #(.NUM_PINS(NUM_PINS), .CASCADE_LVL(CASCADE_LVL)) u_xbar (
      .pins_i  (ext_irq),
      .route_i (route_q),
      .lines_o (lines)
   );

   always_comb begin
      m_line              = lines[LVL_N-1:0];
      m_line[CASCADE_LVL] = s_req;
   end
   assign s_line = lines[LINES_N-1:LVL_N];

   irq_pic_core #(.LEVEL_BITS('0)) u_slave (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (s_line),
      .mask_i (s_mask),
      .ack_i  (s_ack),
      .eoi_i  (eoi_valid && eoi_slave),
      .req_o  (s_req),
      .top_o  (s_top),
      .evt_o  (s_evt)
   );

   irq_pic_core #(.LEVEL_BITS(CASC_BIT)) u_master (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (m_line),
      .mask_i (m_mask),
      .ack_i  (inta),
      .eoi_i  (eoi_valid && !eoi_slave),
      .req_o  (m_req),
      .top_o  (m_top),
      .evt_o  (m_evt)
   );

   assign s_ack   = inta && m_req && (m_top == IDX_W'(CASCADE_LVL));
   assign int_req = m_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_valid <= 1'b0;
         vec_out   <= '0;
         wake      <= 1'b0;
      end else begin
         vec_valid <= inta;
         wake      <= m_evt | s_evt;
         if (inta) begin
            if (!m_req)     vec_out <= {m_base_q, {IDX_W{1'b1}}};
            else if (s_ack) vec_out <= {s_base_q, (s_req ? s_top : {IDX_W{1'b1}})};
            else            vec_out <= {m_base_q, m_top};
         end
      end
   end
endmodule

// File: rtl/irq_cascade_router_chk.sv
module irq_cascade_router_chk #(
   parameter int unsigned NUM_PINS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_PINS-1:0] ext_irq,
   input logic                cfg_we,
   input logic                inta,
   input logic                eoi_valid,
   input logic                int_req,
   input logic                vec_valid,
   input logic [7:0]          vec_out,
   input logic                wake,
   input logic [7:0]          m_mask
);
   p_vec_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      inta |=> vec_valid);

   p_vec_needs_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> $past(inta));

   p_spurious_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && !int_req) |=> (vec_out[2:0] == 3'd7));

   p_all_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (m_mask == 8'hFF) |-> !int_req);

   p_wake_from_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
      wake |-> $past(|ext_irq));

   p_ack_drops_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inta && int_req && !cfg_we && !eoi_valid) |=>
         (!int_req || (ext_irq != $past(ext_irq))));
endmodule

bind irq_cascade_router irq_cascade_router_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ext_irq   (ext_irq),
   .cfg_we    (cfg_we),
   .inta      (inta),
   .eoi_valid (eoi_valid),
   .int_req   (int_req),
   .vec_valid (vec_valid),
   .vec_out   (vec_out),
   .wake      (wake),
   .m_mask    (m_mask)
);

// File: tb/irq_cascade_router_tb.sv
module irq_cascade_router_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ext_irq = '0;
   logic       cfg_we = 1'b0;
   logic [3:0] cfg_addr = '0;
   logic [7:0] cfg_wdata = '0;
   logic       inta = 1'b0;
   logic       eoi_valid = 1'b0;
   logic       eoi_slave = 1'b0;
   logic       int_req, vec_valid, wake;
   logic [7:0] vec_out;
   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_cascade_router u_dut (
      .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .inta(inta),
      .eoi_valid(eoi_valid), .eoi_slave(eoi_slave), .int_req(int_req),
      .vec_valid(vec_valid), .vec_out(vec_out), .wake(wake)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic cfg(input logic [3:0] a, input logic [7:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      tick();
      cfg_we = 1'b0;
   endtask

   task automatic ack(input string tag, input logic [7:0] exp);
      inta = 1'b1;
      tick();
      inta = 1'b0;
      chk({tag, " vec_valid"}, 32'(vec_valid), 32'd1);
      chk({tag, " vector"}, 32'(vec_out), 32'(exp));
   endtask

   task automatic eoi(input logic sl);
      eoi_valid = 1'b1; eoi_slave = sl;
      tick();
      eoi_valid = 1'b0; eoi_slave = 1'b0;
   endtask

   task automatic pins_low();
      ext_irq = '0;
      tick();
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      chk("R1 int_req", 32'(int_req), 0);
      chk("R1 vec_valid", 32'(vec_valid), 0);
      chk("R1 wake", 32'(wake), 0);
      ext_irq[0] = 1'b1;
      tick();
      chk("R3 unrouted int_req", 32'(int_req), 0);
      chk("R3 unrouted wake", 32'(wake), 0);
      tick();
      chk("R3 unrouted int_req later", 32'(int_req), 0);
      pins_low();
   endtask

   task automatic t_master_edge();
      cfg(4'd3, 8'd5);
      ext_irq[3] = 1'b1;
      tick();
      chk("R2 primary latency", 32'(int_req), 1);
      chk("R11 wake pulse", 32'(wake), 1);
      tick();
      chk("R11 wake one cycle", 32'(wake), 0);
      ack("R7 primary 5", 8'h0D);
      chk("R6 req drops after ack", 32'(int_req), 0);
      eoi(1'b0);
      repeat (3) tick();
      chk("R8 held pin no new request", 32'(int_req), 0);
      pins_low();
      ext_irq[3] = 1'b1;
      tick();
      chk("R8 new edge requests", 32'(int_req), 1);
      ack("R8 vector", 8'h0D);
      eoi(1'b0);
      pins_low();
   endtask

   task automatic t_slave();
      cfg(4'd1, 8'd12);
      ext_irq[1] = 1'b1;
      tick();
      chk("R2 secondary first cycle", 32'(int_req), 0);
      tick();
      chk("R2 secondary second cycle", 32'(int_req), 1);
      ack("R7 secondary 12", 8'h74);
      chk("R6 secondary req drops", 32'(int_req), 0);
      pins_low();
      eoi(1'b1);
      eoi(1'b0);
      tick();
      chk("R9 idle after both eoi", 32'(int_req), 0);
   endtask

   task automatic t_mask();
      cfg(4'd8, 8'h40);
      cfg(4'd2, 8'd6);
      ext_irq[2] = 1'b1;
      tick();
      chk("R4 masked no request", 32'(int_req), 0);
      chk("R11 masked no wake", 32'(wake), 0);
      pins_low();
      cfg(4'd8, 8'h00);
      chk("R4 unmask raises request", 32'(int_req), 1);
      ack("R4 pending vector", 8'h0E);
      eoi(1'b0);
   endtask

   task automatic t_priority();
      cfg(4'd0, 8'd7);
      cfg(4'd4, 8'd10);
      cfg(4'd5, 8'd1);
      ext_irq[0] = 1'b1; ext_irq[4] = 1'b1; ext_irq[5] = 1'b1;
      tick();
      tick();
      ack("R5 first level 1", 8'h09);
      chk("R6 lower pending blocked", 32'(int_req), 0);
      eoi(1'b0);
      chk("R5 request after eoi", 32'(int_req), 1);
      ack("R5 second level 10", 8'h72);
      eoi(1'b1);
      eoi(1'b0);
      chk("R5 last pending", 32'(int_req), 1);
      ack("R5 third level 7", 8'h0F);
      eoi(1'b0);
      pins_low();
   endtask

   task automatic t_preempt();
      cfg(4'd0, 8'd4);
      cfg(4'd4, 8'd3);
      cfg(4'd5, 8'd5);
      ext_irq[0] = 1'b1;
      tick();
      ack("R6 level 4", 8'h0C);
      ext_irq[4] = 1'b1;
      tick();
      chk("R6 higher preempts", 32'(int_req), 1);
      ack("R6 level 3", 8'h0B);
      eoi(1'b0);
      ext_irq[5] = 1'b1;
      tick();
      chk("R9 eoi cleared only level 3", 32'(int_req), 0);
      eoi(1'b0);
      chk("R9 second eoi frees level 5", 32'(int_req), 1);
      ack("R9 level 5", 8'h0D);
      eoi(1'b0);
      pins_low();
   endtask

   task automatic t_cascade_eoi();
      cfg(4'd6, 8'd9);
      cfg(4'd7, 8'd13);
      ext_irq[6] = 1'b1;
      tick();
      tick();
      ack("R9 level 9", 8'h71);
      eoi(1'b1);
      ext_irq[7] = 1'b1;
      tick();
      tick();
      chk("R9 primary still in service", 32'(int_req), 0);
      eoi(1'b0);
      chk("R9 primary eoi releases", 32'(int_req), 1);
      ack("R9 level 13", 8'h75);
      eoi(1'b1);
      eoi(1'b0);
      pins_low();
   endtask

   task automatic t_spurious();
      chk("R10 idle", 32'(int_req), 0);
      ack("R10 spurious", 8'h0F);
      chk("R10 no request", 32'(int_req), 0);
      cfg(4'd5, 8'd7);
      ext_irq[5] = 1'b1;
      tick();
      chk("R10 level 7 not in service", 32'(int_req), 1);
      ack("R10 real level 7", 8'h0F);
      eoi(1'b0);
      pins_low();
   endtask

   task automatic t_base();
      cfg(4'd10, 8'hA0);
      cfg(4'd11, 8'hC8);
      cfg(4'd0, 8'd0);
      cfg(4'd4, 8'd15);
      ext_irq[0] = 1'b1;
      tick();
      ack("R7 primary base", 8'hA0);
      eoi(1'b0);
      ext_irq[4] = 1'b1;
      tick();
      tick();
      ack("R7 secondary base", 8'hCF);
      eoi(1'b1);
      eoi(1'b0);
      pins_low();
   endtask

   initial begin
      t_reset();
      t_master_edge();
      t_slave();
      t_mask();
      t_priority();
      t_preempt();
      t_cascade_eoi();
      t_spurious();
      t_base();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule